// File: doc/BRIEF.md
# Level-One Address Translation Buffer with Blocking Requester Ports

This block caches virtual-to-physical page translations for a three-level, 39-bit virtual memory scheme. It is fully associative and holds 4 KiB, 2 MiB and 1 GiB leaves. Several requester ports share it. Each port is fixed at elaboration as either non-blocking or blocking. A non-blocking port always answers on the cycle after a request and flags a miss. A blocking port parks a missed request in its own slot and stays not-ready until the slot is resolved.

Misses go to an external page-table walker over a valid/ready request channel. Only one walk is outstanding at a time. The walk response refills the array and is forwarded straight to any blocking slot that waits on the same page.

There are two flush inputs, and they do different jobs:
- The translation flush clears the cached translations and forgets the outstanding walk. It leaves blocking slots in place, and those slots ask for their walk again.
- The pipeline flush is the only thing that releases blocking slots. Each released slot answers with a page-fault-marked response that the requester discards.

A change of the root page-table number acts as a translation flush, one cycle late. When translation is off, requests complete with an identity mapping. Translation is off when the enable input is low or the privilege input is machine level.

Top module: `xlat_cache`

## Requirements
- R1: After reset no port answers, no walk is requested, and every port is ready.
- R2: A non-blocking port answers each request on the next cycle. It raises the miss flag when no entry covers the page, and a missed page is then requested from the walker.
- R3: A blocking port that misses keeps the request. It drops ready and gives no answer until a walk response covers the page. It then answers on the cycle after that response.
- R4: The walk response level encodes 0 = 4 KiB, 1 = 2 MiB and 2 = 1 GiB. The physical page number returned takes its low 9×level bits from the virtual page number and the rest from the response.
- R5: A walk response installs an entry. Later lookups anywhere inside that page hit with the composed page number. Eight entries are replaced round-robin, and the pointer returns to entry 0 on a translation flush, so the ninth fill after a flush evicts the first.
- R6: With the enable input low, or the privilege input equal to 3 (machine), requests are answered with the virtual page number zero-extended. A waiting blocking slot is also answered that way, on the next cycle, instead of taking a walk response.
- R7: A pipeline flush makes a waiting blocking slot answer on the next cycle with valid and page-fault high, then frees it. A blocking request accepted in the same cycle as the pipeline flush is answered the same way and is not held.
- R8: A translation flush invalidates every entry and forgets the outstanding walk. A waiting blocking slot stays held and raises its walk request again on the next cycle.
- R9: At most one walk is outstanding. When several ports need a walk, the lowest port index is sent first.
- R10: A blocking request that misses while its kill input is high is answered next cycle with the miss flag. It is not held and no walk is requested.
- R11: A change of the root page-table input flushes translations two edges later. Lookups accepted at the first and second edges after the change still hit, and the third misses.
- R12: A blocking request that hits in the same cycle as a translation flush is still answered on the next cycle with the cached page number.
- R13: A page-fault flag in a walk response is returned to the waiting slot and by later hits on that entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| xlat_en | input | 1 | Translation enable from the address-mode setting |
| priv_lvl | input | 2 | Current privilege level, 3 = machine |
| root_ppn | input | 44 | Root page-table page number; a change flushes |
| flush_mmu | input | 1 | Translation-state flush |
| flush_pipe | input | 1 | Pipeline flush, releases blocking slots |
| req_valid | input | NPORT | Request valid per port |
| req_ready | output | NPORT | Request ready per port |
| req_kill | input | NPORT | Do not hold this miss (blocking ports) |
| req_vpn | input | NPORT×27 | Virtual page number per port |
| resp_valid | output | NPORT | Response valid per port |
| resp_miss | output | NPORT | Response is a miss |
| resp_pf | output | NPORT | Page fault |
| resp_ppn | output | NPORT×44 | Physical page number per port |
| walk_req_valid | output | 1 | Walk request valid |
| walk_req_ready | input | 1 | Walker accepts the request |
| walk_req_vpn | output | 27 | Page to walk |
| walk_resp_valid | input | 1 | Walk response valid |
| walk_resp_vpn | input | 27 | Page that was walked |
| walk_resp_level | input | 2 | Leaf level of the response |
| walk_resp_ppn | input | 44 | Leaf physical page number |
| walk_resp_pf | input | 1 | Walk found a page fault |

## Verification
Every answer is registered once, so a request accepted at a clock edge shows its answer after the following edge. The bench drives inputs on falling edges and samples one falling edge later. A blocking slot is answered one edge after the walk response, pipeline flush or translation disable that resolves it, so the walker task returns exactly at that sampling point. A re-issued walk after a translation flush appears one edge after the flush. The root-change test samples three consecutive lookups to fix the two-edge delay of that flush.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
   localparam int SEG_W   = 9;
   localparam int NUM_LVL = 3;
   localparam int VPN_W   = SEG_W * NUM_LVL;
   localparam int PPN_W   = 44;

   typedef logic [VPN_W-1:0] vpn_t;
   typedef logic [PPN_W-1:0] ppn_t;

   typedef enum logic [1:0] {LVL_4K = 2'd0, LVL_2M = 2'd1, LVL_1G = 2'd2} lvl_e;

   typedef struct packed {
      logic vld;
      vpn_t vpn;
      lvl_e lvl;
      ppn_t ppn;
      logic pf;
   } ent_t;

   // bits of the page number that take part in a match at a given leaf level
   function automatic vpn_t lvl_mask(lvl_e l);
      vpn_t m = '0;
      for (int s = 0; s < NUM_LVL; s++)
         if (s >= int'(l)) m[s*SEG_W +: SEG_W] = {SEG_W{1'b1}};
      return m;
   endfunction

   // superpage leaves keep the low virtual segments
   function automatic ppn_t join_ppn(ppn_t p, vpn_t v, lvl_e l);
      ppn_t r = p;
      for (int s = 0; s < NUM_LVL; s++)
         if (s < int'(l)) r[s*SEG_W +: SEG_W] = v[s*SEG_W +: SEG_W];
      return r;
   endfunction

   function automatic ppn_t ident_ppn(vpn_t v);
      return {{(PPN_W-VPN_W){1'b0}}, v};
   endfunction
endpackage

// File: rtl/xlat_entries.sv
module xlat_entries import xlat_pkg::*; #(
   parameter int NPORT   = 2,
   parameter int ENTRIES = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic flush,
   input  vpn_t lk_vpn [NPORT],
   output logic lk_hit [NPORT],
   output ppn_t lk_ppn [NPORT],
   output logic lk_pf  [NPORT],
   input  logic fill_en,
   input  vpn_t fill_vpn,
   input  lvl_e fill_lvl,
   input  ppn_t fill_ppn,
   input  logic fill_pf
);
   localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

   ent_t             tab [ENTRIES];
   logic [IDX_W-1:0] rr_q;
   logic             same_hit;
   logic [IDX_W-1:0] same_idx;
   logic [IDX_W-1:0] wr_idx;

   for (genvar p = 0; p < NPORT; p++) begin : g_look
      logic h;
      ppn_t q;
      logic f;
      always_comb begin
         h = 1'b0;
         q = '0;
         f = 1'b0;
         for (int e = 0; e < ENTRIES; e++) begin
            if (!h && tab[e].vld &&
                (((tab[e].vpn ^ lk_vpn[p]) & lvl_mask(tab[e].lvl)) == '0)) begin
               h = 1'b1;
               q = join_ppn(tab[e].ppn, lk_vpn[p], tab[e].lvl);
               f = tab[e].pf;
            end
         end
      end
      assign lk_hit[p] = h;
      assign lk_ppn[p] = q;
      assign lk_pf[p]  = f;
   end

   always_comb begin
      same_hit = 1'b0;
      same_idx = '0;
      for (int e = 0; e < ENTRIES; e++) begin
         if (!same_hit && tab[e].vld && tab[e].vpn == fill_vpn && tab[e].lvl == fill_lvl) begin
            same_hit = 1'b1;
            same_idx = IDX_W'(e);
         end
      end
      wr_idx = same_hit ? same_idx : rr_q;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rr_q <= '0;
         for (int e = 0; e < ENTRIES; e++) tab[e] <= '0;
      end else if (flush) begin
         rr_q <= '0;
         for (int e = 0; e < ENTRIES; e++) tab[e].vld <= 1'b0;
      end else if (fill_en) begin
         tab[wr_idx] <= '{vld: 1'b1, vpn: fill_vpn, lvl: fill_lvl, ppn: fill_ppn, pf: fill_pf};
         if (!same_hit)
            rr_q <= (rr_q == IDX_W'(ENTRIES-1)) ? '0 : rr_q + 1'b1;
      end
   end
endmodule

// File: rtl/xlat_walk_arb.sv
module xlat_walk_arb import xlat_pkg::*; #(
   parameter int NPORT = 2
) (
   input  logic [NPORT-1:0] need,
   input  vpn_t             need_vpn [NPORT],
   input  logic             busy,
   output logic             out_valid,
   output vpn_t             out_vpn,
   output logic [NPORT-1:0] grant
);
   always_comb begin
      grant   = '0;
      out_vpn = '0;
      for (int p = NPORT-1; p >= 0; p--) begin
         if (need[p]) begin
            grant   = '0;
            grant[p] = 1'b1;
            out_vpn = need_vpn[p];
         end
      end
      out_valid = (|need) && !busy;
      if (busy) grant = '0;
   end
endmodule

// File: rtl/xlat_port.sv
module xlat_port import xlat_pkg::*; #(
   parameter bit BLOCKING = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic req_valid,
   input  vpn_t req_vpn,
   input  logic req_kill,
   output logic req_ready,
   input  logic xlat_on,
   input  logic flush_mmu,
   input  logic flush_pipe,
   input  logic lk_hit,
   input  ppn_t lk_ppn,
   input  logic lk_pf,
   input  logic wr_valid,
   input  vpn_t wr_vpn,
   input  lvl_e wr_lvl,
   input  ppn_t wr_ppn,
   input  logic wr_pf,
   input  logic grant_fire,
   output logic need_walk,
   output vpn_t pend_vpn,
   output logic resp_valid,
   output ppn_t resp_ppn,
   output logic resp_pf,
   output logic resp_miss
);
   logic rv_n, pf_n, miss_n;
   ppn_t ppn_n;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         resp_valid <= 1'b0;
         resp_ppn   <= '0;
         resp_pf    <= 1'b0;
         resp_miss  <= 1'b0;
      end else begin
         resp_valid <= rv_n;
         resp_ppn   <= ppn_n;
         resp_pf    <= pf_n;
         resp_miss  <= miss_n;
      end
   end

   if (BLOCKING) begin : g_blk
      logic busy_q, need_q, busy_n, need_n;
      vpn_t vpn_q, vpn_n;
      logic fire, slot_match;

      assign req_ready  = !busy_q;
      assign fire       = req_valid && !busy_q;
      assign slot_match = busy_q && wr_valid &&
                          (((vpn_q ^ wr_vpn) & lvl_mask(wr_lvl)) == '0);
      assign need_walk  = need_q;
      assign pend_vpn   = vpn_q;

      always_comb begin
         rv_n = 1'b0; ppn_n = '0; pf_n = 1'b0; miss_n = 1'b0;
         busy_n = busy_q; need_n = need_q; vpn_n = vpn_q;
         if (flush_pipe) begin
            busy_n = 1'b0;
            need_n = 1'b0;
            if (busy_q || fire) begin
               rv_n = 1'b1;
               pf_n = 1'b1;
            end
         end else if (fire) begin
            if (!xlat_on) begin
               rv_n = 1'b1; ppn_n = ident_ppn(req_vpn);
            end else if (lk_hit) begin
               rv_n = 1'b1; ppn_n = lk_ppn; pf_n = lk_pf;
            end else if (req_kill) begin
               rv_n = 1'b1; miss_n = 1'b1;
            end else begin
               busy_n = 1'b1; need_n = 1'b1; vpn_n = req_vpn;
            end
         end else if (busy_q) begin
            if (!xlat_on) begin
               rv_n = 1'b1; ppn_n = ident_ppn(vpn_q);
               busy_n = 1'b0; need_n = 1'b0;
            end else if (slot_match) begin
               rv_n = 1'b1; ppn_n = join_ppn(wr_ppn, vpn_q, wr_lvl); pf_n = wr_pf;
               busy_n = 1'b0; need_n = 1'b0;
            end else if (flush_mmu) begin
               need_n = 1'b1;
            end else if (grant_fire) begin
               need_n = 1'b0;
            end
         end
      end

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            busy_q <= 1'b0; need_q <= 1'b0; vpn_q <= '0;
         end else begin
            busy_q <= busy_n; need_q <= need_n; vpn_q <= vpn_n;
         end
      end
   end else begin : g_nblk
      logic pn_q;
      vpn_t pv_q;
      logic nb_unused;

      assign req_ready = 1'b1;
      assign need_walk = pn_q;
      assign pend_vpn  = pv_q;
      assign nb_unused = ^{req_kill, wr_valid, wr_vpn, wr_lvl, wr_ppn, wr_pf, flush_pipe};

      always_comb begin
         rv_n = req_valid; ppn_n = '0; pf_n = 1'b0; miss_n = 1'b0;
         if (req_valid) begin
            if (!xlat_on)    ppn_n = ident_ppn(req_vpn);
            else if (lk_hit) begin ppn_n = lk_ppn; pf_n = lk_pf; end
            else             miss_n = 1'b1;
         end
      end

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            pn_q <= 1'b0; pv_q <= '0;
         end else if (flush_mmu) begin
            pn_q <= 1'b0;
         end else if (req_valid && xlat_on && !lk_hit) begin
            pn_q <= 1'b1; pv_q <= req_vpn;
         end else if (grant_fire) begin
            pn_q <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/xlat_cache.sv
module xlat_cache import xlat_pkg::*; #(
   parameter int               NPORT     = 2,
   parameter logic [NPORT-1:0] BLOCK_MAP = 2'b10,
   parameter int               ENTRIES   = 8
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   xlat_en,
   input  logic [1:0]             priv_lvl,
   input  logic [PPN_W-1:0]       root_ppn,
   input  logic                   flush_mmu,
   input  logic                   flush_pipe,
   input  logic [NPORT-1:0]       req_valid,
   output logic [NPORT-1:0]       req_ready,
   input  logic [NPORT-1:0]       req_kill,
   input  logic [NPORT*VPN_W-1:0] req_vpn,
   output logic [NPORT-1:0]       resp_valid,
   output logic [NPORT-1:0]       resp_miss,
   output logic [NPORT-1:0]       resp_pf,
   output logic [NPORT*PPN_W-1:0] resp_ppn,
   output logic                   walk_req_valid,
   input  logic                   walk_req_ready,
   output logic [VPN_W-1:0]       walk_req_vpn,
   input  logic                   walk_resp_valid,
   input  logic [VPN_W-1:0]       walk_resp_vpn,
   input  logic [1:0]             walk_resp_level,
   input  logic [PPN_W-1:0]       walk_resp_ppn,
   input  logic                   walk_resp_pf
);
   if (NPORT < 1 || NPORT > 8)       $error("NPORT must be 1..8");
   if (ENTRIES < 2 || ENTRIES > 64)  $error("ENTRIES must be 2..64");

   localparam logic [1:0] PRIV_MACHINE = 2'd3;

   ppn_t root_q, root_qq;
   logic root_chg, flush_all, xlat_on, inflight_q, wr_ok;
   logic [NPORT-1:0] need, grant;
   vpn_t lk_vpn [NPORT];
   vpn_t pend_vpn [NPORT];
   logic lk_hit [NPORT];
   ppn_t lk_ppn [NPORT];
   logic lk_pf  [NPORT];
   lvl_e wr_lvl;

   assign xlat_on   = xlat_en && (priv_lvl != PRIV_MACHINE);
   assign root_chg  = (root_q != root_qq);
   assign flush_all = flush_mmu || root_chg;
   assign wr_ok     = walk_resp_valid && inflight_q && !flush_all;
   assign wr_lvl    = lvl_e'(walk_resp_level);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         root_q <= '0; root_qq <= '0; inflight_q <= 1'b0;
      end else begin
         root_q  <= root_ppn;
         root_qq <= root_q;
         if (flush_all || walk_resp_valid) inflight_q <= 1'b0;
         else if (walk_req_valid && walk_req_ready) inflight_q <= 1'b1;
      end
   end

   xlat_entries #(.NPORT(NPORT), .ENTRIES(ENTRIES)) u_ent (
      .clk(clk), .rst_n(rst_n), .flush(flush_all),
      .lk_vpn(lk_vpn), .lk_hit(lk_hit), .lk_ppn(lk_ppn), .lk_pf(lk_pf),
      .fill_en(wr_ok), .fill_vpn(walk_resp_vpn), .fill_lvl(wr_lvl),
      .fill_ppn(walk_resp_ppn), .fill_pf(walk_resp_pf)
   );

   xlat_walk_arb #(.NPORT(NPORT)) u_arb (
      .need(need), .need_vpn(pend_vpn), .busy(inflight_q),
      .out_valid(walk_req_valid), .out_vpn(walk_req_vpn), .grant(grant)
   );

   for (genvar p = 0; p < NPORT; p++) begin : g_port
      assign lk_vpn[p] = req_vpn[p*VPN_W +: VPN_W];
      xlat_port #(.BLOCKING(BLOCK_MAP[p])) u_port (
         .clk(clk), .rst_n(rst_n),
         .req_valid(req_valid[p]), .req_vpn(req_vpn[p*VPN_W +: VPN_W]),
         .req_kill(req_kill[p]), .req_ready(req_ready[p]),
         .xlat_on(xlat_on), .flush_mmu(flush_all), .flush_pipe(flush_pipe),
         .lk_hit(lk_hit[p]), .lk_ppn(lk_ppn[p]), .lk_pf(lk_pf[p]),
         .wr_valid(wr_ok), .wr_vpn(walk_resp_vpn), .wr_lvl(wr_lvl),
         .wr_ppn(walk_resp_ppn), .wr_pf(walk_resp_pf),
         .grant_fire(grant[p] && walk_req_ready && !flush_all),
         .need_walk(need[p]), .pend_vpn(pend_vpn[p]),
         .resp_valid(resp_valid[p]), .resp_ppn(resp_ppn[p*PPN_W +: PPN_W]),
         .resp_pf(resp_pf[p]), .resp_miss(resp_miss[p])
      );
   end
endmodule

// File: rtl/xlat_cache_chk.sv
module xlat_cache_chk import xlat_pkg::*; #(
   parameter int               NPORT     = 2,
   parameter logic [NPORT-1:0] BLOCK_MAP = 2'b10
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic                   xlat_en,
   input logic [1:0]             priv_lvl,
   input logic                   flush_pipe,
   input logic                   flush_all,
   input logic [NPORT-1:0]       req_valid,
   input logic [NPORT-1:0]       req_ready,
   input logic [NPORT*VPN_W-1:0] req_vpn,
   input logic [NPORT-1:0]       resp_valid,
   input logic [NPORT-1:0]       resp_pf,
   input logic [NPORT*PPN_W-1:0] resp_ppn,
   input logic                   walk_req_valid,
   input logic                   walk_req_ready
);
   // R9: after an accepted walk no second request until it is resolved
   p_one_walk_r9: assert property (@(posedge clk) disable iff (!rst_n)
      walk_req_valid && walk_req_ready && !flush_all |=> !walk_req_valid);

   for (genvar i = 0; i < NPORT; i++) begin : g_chk
      if (BLOCK_MAP[i]) begin : g_b
         // R3: an accepted blocking request is answered or held
         p_answer_or_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
            req_valid[i] && req_ready[i] && !flush_pipe |=> resp_valid[i] || !req_ready[i]);
         // R7: pipeline flush answers a held slot with a fault
         p_pipe_flush_pf_r7: assert property (@(posedge clk) disable iff (!rst_n)
            flush_pipe && !req_ready[i] |=> resp_valid[i] && resp_pf[i] && req_ready[i]);
      end else begin : g_n
         // R2: non-blocking port answers on the next cycle
         p_next_resp_r2: assert property (@(posedge clk) disable iff (!rst_n)
            req_valid[i] |=> resp_valid[i]);
         // R6: identity mapping with translation off
         p_identity_r6: assert property (@(posedge clk) disable iff (!rst_n)
            req_valid[i] && !(xlat_en && priv_lvl != 2'd3) |=>
            resp_ppn[i*PPN_W +: PPN_W] == {{(PPN_W-VPN_W){1'b0}}, $past(req_vpn[i*VPN_W +: VPN_W])});
      end
   end
endmodule

bind xlat_cache xlat_cache_chk #(.NPORT(NPORT), .BLOCK_MAP(BLOCK_MAP)) u_chk (
   .clk(clk), .rst_n(rst_n), .xlat_en(xlat_en), .priv_lvl(priv_lvl),
   .flush_pipe(flush_pipe), .flush_all(flush_all),
   .req_valid(req_valid), .req_ready(req_ready), .req_vpn(req_vpn),
   .resp_valid(resp_valid), .resp_pf(resp_pf), .resp_ppn(resp_ppn),
   .walk_req_valid(walk_req_valid), .walk_req_ready(walk_req_ready)
);

// File: tb/xlat_cache_bench.sv
module xlat_cache_bench;
   localparam int VW = 27;
   localparam int PW = 44;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic xlat_en = 1'b1;
   logic [1:0] priv_lvl = 2'd0;
   logic [PW-1:0] root_ppn = '0;
   logic flush_mmu = 1'b0, flush_pipe = 1'b0;
   logic [1:0] req_valid = '0, req_kill = '0;
   logic [2*VW-1:0] req_vpn = '0;
   logic [1:0] req_ready, resp_valid, resp_miss, resp_pf;
   logic [2*PW-1:0] resp_ppn;
   logic walk_req_valid;
   logic walk_req_ready = 1'b1;
   logic [VW-1:0] walk_req_vpn;
   logic walk_resp_valid = 1'b0;
   logic [VW-1:0] walk_resp_vpn = '0;
   logic [1:0] walk_resp_level = '0;
   logic [PW-1:0] walk_resp_ppn = '0;
   logic walk_resp_pf = 1'b0;

   int tests = 0, fails = 0;

   always #2 clk = ~clk;

   xlat_cache u_xlat_cache (
      .clk(clk), .rst_n(rst_n), .xlat_en(xlat_en), .priv_lvl(priv_lvl),
      .root_ppn(root_ppn), .flush_mmu(flush_mmu), .flush_pipe(flush_pipe),
      .req_valid(req_valid), .req_ready(req_ready), .req_kill(req_kill),
      .req_vpn(req_vpn), .resp_valid(resp_valid), .resp_miss(resp_miss),
      .resp_pf(resp_pf), .resp_ppn(resp_ppn),
      .walk_req_valid(walk_req_valid), .walk_req_ready(walk_req_ready),
      .walk_req_vpn(walk_req_vpn), .walk_resp_valid(walk_resp_valid),
      .walk_resp_vpn(walk_resp_vpn), .walk_resp_level(walk_resp_level),
      .walk_resp_ppn(walk_resp_ppn), .walk_resp_pf(walk_resp_pf)
   );

   function automatic logic [PW-1:0] rp(int p);
      return resp_ppn[p*PW +: PW];
   endfunction

   function automatic logic [PW-1:0] mk(logic [PW-1:0] p, logic [VW-1:0] v, int lvl);
      logic [PW-1:0] m = (44'd1 << (9*lvl)) - 44'd1;
      return (p & ~m) | ({17'd0, v} & m);
   endfunction

   task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic send(input int p, input logic [VW-1:0] v, input bit k);
      @(negedge clk);
      req_valid[p] = 1'b1; req_vpn[p*VW +: VW] = v; req_kill[p] = k;
      @(negedge clk);
      req_valid[p] = 1'b0; req_kill[p] = 1'b0;
   endtask

   task automatic pulse_mmu();
      @(negedge clk); flush_mmu = 1'b1;
      @(negedge clk); flush_mmu = 1'b0;
   endtask

   // returns at the falling edge where a slot answer to this response is visible
   task automatic walk(input logic [VW-1:0] v, input int lvl, input logic [PW-1:0] p,
                       input bit pf, input string tag);
      int n = 0;
      while (!walk_req_valid && n < 20) begin @(negedge clk); n++; end
      check(walk_req_valid && walk_req_vpn == v, tag, 64'(walk_req_vpn), 64'(v));
      @(negedge clk);
      walk_resp_valid = 1'b1; walk_resp_vpn = v; walk_resp_level = 2'(lvl);
      walk_resp_ppn = p; walk_resp_pf = pf;
      @(negedge clk);
      walk_resp_valid = 1'b0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      fails++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      logic [VW-1:0] v, v2, va, vb;
      logic [PW-1:0] p, pb;
      logic [26:0] m;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check(resp_valid == 2'b00 && !walk_req_valid && req_ready == 2'b11, "R1 reset",
            {resp_valid, walk_req_valid, req_ready}, 64'h3);

      // R6 identity with translation off
      xlat_en = 1'b0;
      send(0, 27'h12345, 1'b0);
      check(resp_valid[0] && !resp_miss[0] && rp(0) == 44'h12345, "R6 enable low", rp(0), 44'h12345);
      xlat_en = 1'b1; priv_lvl = 2'd3;
      send(1, 27'h6789A, 1'b0);
      check(resp_valid[1] && rp(1) == 44'h6789A && req_ready[1], "R6 machine level", rp(1), 44'h6789A);
      priv_lvl = 2'd0;

      // R3 R4 R5 sweep over leaf levels
      for (int lvl = 0; lvl < 3; lvl++) begin
         v = VW'(((lvl+1) << 18) | ((lvl+3) << 9) | (lvl+7));
         p = 44'h12345678 * 44'(lvl+1);
         send(1, v, 1'b0);
         check(!resp_valid[1] && !req_ready[1], "R3 slot held", {resp_valid[1], req_ready[1]}, 0);
         walk(v, lvl, p, 1'b0, "R9 walk vpn");
         check(resp_valid[1] && rp(1) == mk(p, v, lvl), "R4 slot ppn", rp(1), mk(p, v, lvl));
         m = 27'((1 << (9*lvl)) - 1);
         for (int off = 0; off < 4; off++) begin
            v2 = (v & ~m) | ((v + VW'(off*37)) & m);
            send(0, v2, 1'b0);
            check(resp_valid[0] && !resp_miss[0] && rp(0) == mk(p, v2, lvl), "R5 superpage hit",
                  rp(0), mk(p, v2, lvl));
         end
      end

      // R2 non-blocking miss then refill
      send(0, 27'h0ABCD, 1'b0);
      check(resp_valid[0] && resp_miss[0], "R2 miss flag", resp_miss[0], 1);
      walk(27'h0ABCD, 0, 44'h777, 1'b0, "R2 walk request");
      check(!resp_valid[0], "R2 no response from walk", resp_valid[0], 0);
      send(0, 27'h0ABCD, 1'b0);
      check(resp_valid[0] && !resp_miss[0] && rp(0) == 44'h777, "R2 hit after refill", rp(0), 44'h777);

      // R13 page fault
      send(1, 27'h0F00F, 1'b0);
      walk(27'h0F00F, 0, 44'h888, 1'b1, "R13 walk");
      check(resp_valid[1] && resp_pf[1], "R13 slot fault", resp_pf[1], 1);
      send(0, 27'h0F00F, 1'b0);
      check(resp_valid[0] && resp_pf[0] && !resp_miss[0], "R13 hit fault", resp_pf[0], 1);

      // R8 translation flush while a walk is outstanding
      send(1, 27'h05555, 1'b0);
      check(walk_req_valid, "R8 first walk", walk_req_valid, 1);
      @(negedge clk);
      check(!walk_req_valid, "R9 single outstanding", walk_req_valid, 0);
      flush_mmu = 1'b1;
      @(negedge clk);
      flush_mmu = 1'b0;
      check(walk_req_valid && walk_req_vpn == 27'h05555 && !req_ready[1] && !resp_valid[1],
            "R8 walk reissued", 64'(walk_req_vpn), 64'h05555);
      walk(27'h05555, 0, 44'h999, 1'b0, "R8 reissue walk");
      check(resp_valid[1] && rp(1) == 44'h999, "R8 slot answered", rp(1), 44'h999);
      send(0, 27'h0ABCD, 1'b0);
      check(resp_miss[0], "R8 entries cleared", resp_miss[0], 1);
      walk(27'h0ABCD, 0, 44'h777, 1'b0, "R8 cleanup walk");

      // R5 round-robin replacement
      pulse_mmu();
      for (int k = 0; k < 9; k++) begin
         send(1, VW'(27'h100 + k*27'h1000), 1'b0);
         walk(VW'(27'h100 + k*27'h1000), 0, 44'(44'h500 + k), 1'b0, "R5 fill walk");
      end
      for (int k = 1; k < 9; k++) begin
         send(0, VW'(27'h100 + k*27'h1000), 1'b0);
         check(!resp_miss[0] && rp(0) == 44'(44'h500 + k), "R5 retained", rp(0), 44'(44'h500 + k));
      end
      send(0, 27'h100, 1'b0);
      check(resp_miss[0], "R5 oldest evicted", resp_miss[0], 1);
      walk(27'h100, 0, 44'h500, 1'b0, "R5 cleanup walk");
      pulse_mmu();

      // R7 pipeline flush of a waiting slot
      send(1, 27'h03333, 1'b0);
      @(negedge clk); flush_pipe = 1'b1;
      @(negedge clk); flush_pipe = 1'b0;
      check(resp_valid[1] && resp_pf[1] && req_ready[1], "R7 slot released",
            {resp_valid[1], resp_pf[1], req_ready[1]}, 64'h7);
      pulse_mmu();
      @(negedge clk);
      req_valid[1] = 1'b1; req_vpn[VW +: VW] = 27'h04444; flush_pipe = 1'b1;
      @(negedge clk);
      req_valid[1] = 1'b0; flush_pipe = 1'b0;
      check(resp_valid[1] && resp_pf[1] && req_ready[1] && !walk_req_valid, "R7 same-cycle request",
            {resp_valid[1], resp_pf[1], req_ready[1], walk_req_valid}, 64'hE);

      // R10 kill
      send(1, 27'h02222, 1'b1);
      check(resp_valid[1] && resp_miss[1] && req_ready[1] && !walk_req_valid, "R10 kill",
            {resp_valid[1], resp_miss[1], req_ready[1], walk_req_valid}, 64'hE);

      // R6 waiting slot completed by identity when translation turns off
      send(1, 27'h01111, 1'b0);
      xlat_en = 1'b0;
      @(negedge clk);
      check(resp_valid[1] && rp(1) == 44'h01111 && req_ready[1], "R6 slot identity", rp(1), 44'h01111);
      xlat_en = 1'b1;
      pulse_mmu();

      // R9 priority: lower port first
      va = 27'h0AAAA; vb = 27'h0BBBB; pb = 44'hBB00;
      @(negedge clk);
      req_valid = 2'b11; req_vpn = {vb, va};
      @(negedge clk);
      req_valid = 2'b00;
      check(walk_req_valid && walk_req_vpn == va, "R9 priority", 64'(walk_req_vpn), 64'(va));
      walk(va, 0, 44'hAA00, 1'b0, "R9 first walk");
      walk(vb, 0, pb, 1'b0, "R9 second walk");
      check(resp_valid[1] && rp(1) == pb, "R9 second slot answer", rp(1), pb);

      // R12 blocking hit with translation flush in the same cycle
      @(negedge clk);
      req_valid[1] = 1'b1; req_vpn[VW +: VW] = vb; flush_mmu = 1'b1;
      @(negedge clk);
      req_valid[1] = 1'b0; flush_mmu = 1'b0;
      check(resp_valid[1] && !resp_miss[1] && rp(1) == pb, "R12 answered", rp(1), pb);
      send(0, vb, 1'b0);
      check(resp_miss[0], "R12 flush took effect", resp_miss[0], 1);
      walk(vb, 0, pb, 1'b0, "R12 cleanup walk");

      // R11 root change flushes two edges later
      @(negedge clk);
      root_ppn = 44'h5; req_valid[0] = 1'b1; req_vpn[0 +: VW] = vb;
      @(negedge clk);
      check(!resp_miss[0] && rp(0) == pb, "R11 first edge hit", resp_miss[0], 0);
      @(negedge clk);
      check(!resp_miss[0] && rp(0) == pb, "R11 second edge hit", resp_miss[0], 0);
      @(negedge clk);
      req_valid[0] = 1'b0;
      check(resp_valid[0] && resp_miss[0], "R11 third edge miss", resp_miss[0], 1);
      walk(vb, 0, pb, 1'b0, "R11 cleanup walk");

      repeat (2) @(negedge clk);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule